// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Splitter

This block connects a 16-bit requester, which asks for a byte or a word at any byte address, to a memory made of two 8-bit banks. The even bank holds the even byte addresses and uses data lanes 7:0. The odd bank holds the odd byte addresses and uses lanes 15:8. For each accepted request the block issues one or two bank cycles. Each bank cycle carries the word address (byte address bits above bit 0), the even-bank select `cyc_a0_o` (active low), the odd-bank select `cyc_bhe_n_o` (active low), a write strobe and steered write data. Read data from the banks is moved back so that a byte always reaches the requester on bits 7:0.

A byte access, or a word on an even address, needs one bank cycle. A word on an odd address crosses a word boundary. The block splits it into two single-byte cycles in a fixed order. First comes the low byte at the odd address, on the odd bank. Then comes the high byte at the following even address, on the even bank, with the word address one higher. The block joins the two halves of such a read into one result.

The controller has four states:
- `ST_IDLE`: no bank cycle.
- `ST_SOLO`: the single cycle of an unsplit access.
- `ST_LOW`: the first half of a split word.
- `ST_HIGH`: the second half of a split word.

Its transitions are:
- IDLE to SOLO on a request that is not an odd-address word.
- IDLE to LOW on an odd-address word.
- LOW to HIGH, always.
- SOLO to IDLE and HIGH to IDLE, always. Both raise the completion pulse.
- IDLE to IDLE with no request.

Top module: `byte_lane_splitter`

## Requirements
- R1: A byte request at an even address gives exactly one bank cycle with `cyc_a0_o`=0 and `cyc_bhe_n_o`=1, and with word address = byte address >> 1. On a write, `req_wdata_i[7:0]` appears on `cyc_wdata_o[7:0]` and lanes 15:8 are zero. On a read, `rdata_o` = {8'h00, `cyc_rdata_i[7:0]`}.
- R2: A byte request at an odd address gives exactly one bank cycle with `cyc_a0_o`=1 and `cyc_bhe_n_o`=0, and with word address = byte address >> 1. On a write, `req_wdata_i[7:0]` appears on `cyc_wdata_o[15:8]` and lanes 7:0 are zero. On a read, `rdata_o` = {8'h00, `cyc_rdata_i[15:8]`}.
- R3: A word request at an even address gives exactly one bank cycle with `cyc_a0_o`=0, `cyc_bhe_n_o`=0 and word address = byte address >> 1. A write drives `req_wdata_i` unchanged, and a read returns `cyc_rdata_i` unchanged.
- R4: A word request at an odd address gives exactly two bank cycles.
  - The first has `cyc_a0_o`=1, `cyc_bhe_n_o`=0, word address = byte address >> 1, and on a write `cyc_wdata_o` = {`req_wdata_i[7:0]`, 8'h00}.
  - The second has `cyc_a0_o`=0, `cyc_bhe_n_o`=1, and on a write `cyc_wdata_o` = {8'h00, `req_wdata_i[15:8]`}.
- R5: A word read at an odd address returns `rdata_o[7:0]` = lanes 15:8 from the first cycle and `rdata_o[15:8]` = lanes 7:0 from the second cycle.
- R6: The second cycle of a split word follows the first on the very next clock.
- R7: The word address of the second cycle is one more than that of the first, modulo 2^(ADDR_W-1). The highest odd byte address therefore continues at word address 0.
- R8: A request is taken on a rising edge where `req_valid_i` is 1 and the block is idle. The first bank cycle is presented in the following clock. `done_o` is high for exactly one clock, the clock after the last bank cycle, and `rdata_o` of a read is valid from that clock on.
- R9: `busy_o` is 1 from the clock after acceptance through the last bank cycle and 0 in the `done_o` clock. A `req_valid_i` seen while busy has no effect: no extra bank cycle follows and the write strobe keeps the accepted request's direction.
- R10: While no bank cycle is presented, `cyc_valid_o`=0, `cyc_a0_o`=1, `cyc_bhe_n_o`=1 and `cyc_we_o`=0. During a bank cycle, `cyc_we_o` equals the accepted request's write flag.
- R11: After reset, `busy_o`=0, `done_o`=0, `rdata_o`=0 and the bank side is idle as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 2*LANE_W | Write data; a byte uses bits 7:0 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 2*LANE_W | Read result; a byte is returned on bits 7:0 |
| cyc_valid_o | output | 1 | Bank cycle presented this clock |
| cyc_waddr_o | output | ADDR_W-1 | Word address for both banks |
| cyc_a0_o | output | 1 | Even bank select, active low |
| cyc_bhe_n_o | output | 1 | Odd bank select, active low |
| cyc_we_o | output | 1 | Write strobe for the cycle |
| cyc_wdata_o | output | 2*LANE_W | Steered write lanes |
| cyc_rdata_i | input | 2*LANE_W | Read lanes from the banks |

## Verification
The bench uses a 10-bit address. At every byte address it writes and then reads both a byte and a word, so even bytes, odd bytes, aligned words and split words all occur at each location. The split word at the top address shows that the second cycle wraps to word 0. Per-cycle checks of the select codes, the word address and the lane contents separate the even-lane cases from the odd-lane cases and catch a swapped split order. A memory shadow kept in the bench, together with neighbour-byte checks, catches a write that lands on the wrong bank or on the wrong word. Every fifth access holds a second request through its busy clocks, with the opposite direction and a different address. This shows that such a request is dropped and that it changes neither the write strobe nor the cycle count.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOLO = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } bls_state_e;

    typedef enum logic [1:0] {
        LN_OFF  = 2'd0,
        LN_EVEN = 2'd1,
        LN_ODD  = 2'd2,
        LN_PAIR = 2'd3
    } bls_lane_e;

endpackage

// File: rtl/bls_addr_step.sv
module bls_addr_step #(
    parameter int WA_W = 19
) (
    input  logic [WA_W-1:0] waddr_i,
    output logic [WA_W-1:0] waddr_next_o
);

    // Next word location; natural overflow gives the wrap to zero.
    always_comb begin
        waddr_next_o = waddr_i + {{(WA_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
    import bls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic       req_word_i,
    input  logic       req_odd_i,
    input  logic       word_q_i,
    input  logic       odd_q_i,
    output bls_state_e state_o,
    output bls_lane_e  lane_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       second_o,
    output logic       done_o
);

    bls_state_e state_q, state_d;
    logic       done_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SOLO) || (state_q == ST_HIGH);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    state_d = (req_word_i && req_odd_i) ? ST_LOW : ST_SOLO;
                end
            end
            ST_SOLO: state_d = ST_IDLE;
            ST_LOW:  state_d = ST_HIGH;
            ST_HIGH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        lane_o   = LN_OFF;
        accept_o = 1'b0;
        busy_o   = 1'b1;
        second_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_valid_i;
            end
            ST_SOLO: begin
                if (word_q_i) begin
                    lane_o = LN_PAIR;
                end else begin
                    lane_o = odd_q_i ? LN_ODD : LN_EVEN;
                end
            end
            ST_LOW: lane_o = LN_ODD;
            ST_HIGH: begin
                lane_o   = LN_EVEN;
                second_o = 1'b1;
            end
            default: lane_o = LN_OFF;
        endcase
    end

    assign state_o = state_q;
    assign done_o  = done_q;

    // R6: the high half of a split word follows the low half on the next clock.
    p_split_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |=> (state_q == ST_HIGH));

    // R8: completion is a single-clock pulse.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/bls_write_steer.sv
module bls_write_steer
    import bls_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  bls_lane_e         lane_i,
    input  logic              hi_src_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              a0_o,
    output logic              bhe_n_o
);

    always_comb begin
        bus_o   = '0;
        a0_o    = 1'b1;
        bhe_n_o = 1'b1;
        unique case (lane_i)
            LN_OFF: begin
                bus_o = '0;
            end
            LN_EVEN: begin
                a0_o = 1'b0;
                bus_o[LANE_W-1:0] = hi_src_i ? wdata_i[DATA_W-1:LANE_W]
                                             : wdata_i[LANE_W-1:0];
            end
            LN_ODD: begin
                bhe_n_o = 1'b0;
                bus_o[DATA_W-1:LANE_W] = wdata_i[LANE_W-1:0];
            end
            LN_PAIR: begin
                a0_o    = 1'b0;
                bhe_n_o = 1'b0;
                bus_o   = wdata_i;
            end
            default: bus_o = '0;
        endcase
    end

endmodule

// File: rtl/bls_read_merge.sv
module bls_read_merge
    import bls_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  bls_lane_e         lane_i,
    input  logic              second_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_i) begin
            unique case (lane_i)
                LN_PAIR: rdata_q <= bus_i;
                LN_EVEN: begin
                    if (second_i) begin
                        rdata_q[DATA_W-1:LANE_W] <= bus_i[LANE_W-1:0];
                    end else begin
                        rdata_q <= {{LANE_W{1'b0}}, bus_i[LANE_W-1:0]};
                    end
                end
                LN_ODD:  rdata_q <= {{LANE_W{1'b0}}, bus_i[DATA_W-1:LANE_W]};
                default: rdata_q <= rdata_q;
            endcase
        end
    end

    assign rdata_o = rdata_q;

    // R5: filling the high half of a split word keeps the low half.
    p_merge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && second_i && lane_i == LN_EVEN)
            |=> (rdata_q[LANE_W-1:0] == $past(rdata_q[LANE_W-1:0])));

endmodule

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter
    import bls_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W,
    localparam int WA_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cyc_valid_o,
    output logic [WA_W-1:0]   cyc_waddr_o,
    output logic              cyc_a0_o,
    output logic              cyc_bhe_n_o,
    output logic              cyc_we_o,
    output logic [DATA_W-1:0] cyc_wdata_o,
    input  logic [DATA_W-1:0] cyc_rdata_i
);

    logic [WA_W-1:0]   waddr_q;
    logic [WA_W-1:0]   waddr_inc;
    logic              odd_q;
    logic              word_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    bls_state_e state;
    bls_lane_e  lane;
    logic       accept;
    logic       second;

    // Request capture on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q <= '0;
            odd_q   <= 1'b0;
            word_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            waddr_q <= req_addr_i[ADDR_W-1:1];
            odd_q   <= req_addr_i[0];
            word_q  <= req_word_i;
            write_q <= req_write_i;
            wdata_q <= req_wdata_i;
        end
    end

    bls_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_word_i  (req_word_i),
        .req_odd_i   (req_addr_i[0]),
        .word_q_i    (word_q),
        .odd_q_i     (odd_q),
        .state_o     (state),
        .lane_o      (lane),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .second_o    (second),
        .done_o      (done_o)
    );

    bls_addr_step #(.WA_W(WA_W)) u_step (
        .waddr_i      (waddr_q),
        .waddr_next_o (waddr_inc)
    );

    bls_write_steer #(.LANE_W(LANE_W)) u_steer (
        .lane_i   (lane),
        .hi_src_i (second),
        .wdata_i  (wdata_q),
        .bus_o    (cyc_wdata_o),
        .a0_o     (cyc_a0_o),
        .bhe_n_o  (cyc_bhe_n_o)
    );

    assign cyc_valid_o = (lane != LN_OFF);
    assign cyc_waddr_o = second ? waddr_inc : waddr_q;
    assign cyc_we_o    = cyc_valid_o && write_q;

    bls_read_merge #(.LANE_W(LANE_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cyc_valid_o && !write_q),
        .lane_i   (lane),
        .second_i (second),
        .bus_i    (cyc_rdata_i),
        .rdata_o  (rdata_o)
    );

    // R2: every bank cycle selects at least one bank.
    p_bank_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid_o |-> !(cyc_a0_o && cyc_bhe_n_o));

    // R10: outside an access, both banks are deselected and nothing is written.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cyc_valid_o && cyc_a0_o && cyc_bhe_n_o && !cyc_we_o));

    // R7: the second half addresses the next word location.
    p_next_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (cyc_waddr_o == WA_W'($past(cyc_waddr_o) + 1'b1)));

    // R4: odd bank first, even bank second.
    p_second_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> ($past(cyc_a0_o) && !$past(cyc_bhe_n_o)
                                && !cyc_a0_o && cyc_bhe_n_o));

endmodule

// File: tb/byte_lane_splitter_tb_top.sv
`timescale 1ns/1ps
module byte_lane_splitter_tb_top;

    localparam int AW = 10;
    localparam int N  = 1 << AW;
    localparam int WDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          busy, done, cyc_valid, cyc_a0, cyc_bhe_n, cyc_we;
    logic [15:0]   rdata, cyc_wdata, cyc_rdata;
    logic [AW-2:0] cyc_waddr;

    logic [7:0] mem [N];
    logic [7:0] exp_mem [N];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    byte_lane_splitter #(.ADDR_W(AW), .LANE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_word_i(req_word),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .cyc_valid_o(cyc_valid), .cyc_waddr_o(cyc_waddr), .cyc_a0_o(cyc_a0),
        .cyc_bhe_n_o(cyc_bhe_n), .cyc_we_o(cyc_we), .cyc_wdata_o(cyc_wdata),
        .cyc_rdata_i(cyc_rdata)
    );

    // Two-bank memory model driven by the bank-side codes.
    assign cyc_rdata = {mem[{cyc_waddr, 1'b1}], mem[{cyc_waddr, 1'b0}]};
    always @(posedge clk) begin
        if (cyc_valid && cyc_we) begin
            if (!cyc_a0)    mem[{cyc_waddr, 1'b0}] <= cyc_wdata[7:0];
            if (!cyc_bhe_n) mem[{cyc_waddr, 1'b1}] <= cyc_wdata[15:8];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG) begin
            errors = errors + 1;
            $display("FAIL R8 watchdog expired act=%0d exp<%0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(!cyc_valid && cyc_a0 && cyc_bhe_n && !cyc_we && !busy && !done,
            tag, {cyc_valid, cyc_a0, cyc_bhe_n, cyc_we, busy, done}, 6'b011000);
    endtask

    task automatic do_txn(input int a, input bit word, input bit wr,
                          input logic [15:0] wd, input bit stray);
        int n;
        int a1;
        logic [AW-2:0] ew;
        logic e_a0, e_bhe;
        logic [15:0] ebus, erd;
        a1 = (a + 1) % N;
        n  = (word && a[0]) ? 2 : 1;
        erd = word ? {exp_mem[a1], exp_mem[a]} : {8'h00, exp_mem[a]};
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_word = word;
        req_write = wr;   req_wdata = wd;
        @(negedge clk);
        if (stray) begin
            req_addr  = AW'(a ^ 'h155);
            req_write = ~wr;
            req_word  = ~word;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (!word) begin          // R1 / R2 single byte
                ew = AW'(a) >> 1; e_a0 = a[0]; e_bhe = !a[0];
                ebus = a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
            end else if (!a[0]) begin // R3 aligned word
                ew = AW'(a) >> 1; e_a0 = 1'b0; e_bhe = 1'b0; ebus = wd;
            end else if (k == 0) begin // R4 first half
                ew = AW'(a) >> 1; e_a0 = 1'b1; e_bhe = 1'b0; ebus = {wd[7:0], 8'h00};
            end else begin            // R4 / R7 second half
                ew = AW'(a1) >> 1; e_a0 = 1'b0; e_bhe = 1'b1; ebus = {8'h00, wd[15:8]};
            end
            chk(cyc_valid && busy && !done, "R6_R9 cycle present and busy",
                {cyc_valid, busy, done}, 3'b110);
            chk(cyc_waddr == ew, "R7 word address", cyc_waddr, ew);
            chk({cyc_a0, cyc_bhe_n} == {e_a0, e_bhe}, "R1_R2_R3_R4 bank selects",
                {cyc_a0, cyc_bhe_n}, {e_a0, e_bhe});
            chk(cyc_we == wr, "R10 write strobe follows accepted request", cyc_we, wr);
            if (wr) chk(cyc_wdata == ebus, "R1_R2_R3_R4 write lanes", cyc_wdata, ebus);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && !busy && !cyc_valid, "R8 done pulse after last cycle",
            {done, busy, cyc_valid}, 3'b100);
        if (wr) begin
            exp_mem[a] = wd[7:0];
            if (word) exp_mem[a1] = wd[15:8];
            chk(mem[a] == exp_mem[a], "R4 low byte stored", mem[a], exp_mem[a]);
            chk(mem[a1] == exp_mem[a1], "R4 next byte stored or untouched",
                mem[a1], exp_mem[a1]);
            chk(mem[(a + N - 1) % N] == exp_mem[(a + N - 1) % N], "R1 neighbour untouched",
                mem[(a + N - 1) % N], exp_mem[(a + N - 1) % N]);
            chk(mem[(a + 2) % N] == exp_mem[(a + 2) % N], "R2 neighbour untouched",
                mem[(a + 2) % N], exp_mem[(a + 2) % N]);
        end else begin
            chk(rdata == erd, word ? "R3_R5 word read result" : "R1_R2 byte read result",
                rdata, erd);
        end
        if (stray) begin
            @(negedge clk);
            chk_idle("R9 request while busy ignored");
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 8'hFF);
            exp_mem[i] = 8'((i * 37 + 11) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        chk_idle("R11 reset idle bank side");
        chk(rdata == 16'h0, "R11 reset read result", rdata, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R10 idle after reset release");
        for (int a = 0; a < N; a++) begin
            for (int w = 0; w < 2; w++) begin
                do_txn(a, w[0], 1'b1, 16'((a * 131 + w * 77 + 5) ^ 16'hA5C3),
                       (a % 5) == 0);
                do_txn(a, w[0], 1'b0, 16'h0, (a % 5) == 2);
            end
        end
        // R7 wrap: split word at the top byte address.
        do_txn(N - 1, 1'b1, 1'b1, 16'hBEEF, 1'b0);
        do_txn(N - 1, 1'b1, 1'b0, 16'h0, 1'b0);
        chk(mem[0] == 8'hBE, "R7 wrap high byte at address 0", mem[0], 8'hBE);
        @(negedge clk);
        chk_idle("R10 idle at end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule